// File: doc/BRIEF.md
# Multiframe-Aligned Triggered Capture Controller

This block decides when samples from a framed receive stream get written into a capture buffer. An external trigger arrives with no timing relationship to the frame clock. The block brings it into the frame-clock domain, finds its rising edge and arms itself. It then waits for the next multiframe boundary and only starts writing there. Buffering never begins part-way through a multiframe, so the delay from trigger to first stored frame varies between 1 and K frames.

The multiframe boundary comes from one of two sources. The first is an external start-of-multiframe marker. The second is a local counter that runs over the K frames of a multiframe. Once capture has started, the block writes a programmed number of frames N, one per frame clock, to consecutive buffer addresses starting at zero. It then raises `done` and ignores triggers until software pulses a clear. A latency output reports how many frames passed between trigger detection and the first write.

Top module: `mfcap_ctrl`

## Requirements
- R1: While reset is asserted and in the first frame after release, `wr_en`, `done`, `wr_addr` and `latency` are all zero.
- R2: The trigger passes through two flops, so its rising edge is detected in the second frame clock after it goes high. A trigger level that stays high arms the block only once; it does not arm again after a clear until it has gone low and risen again.
- R3: The first write happens in the first multiframe-boundary frame strictly after the frame in which the trigger edge is detected. A boundary in the detection frame itself is skipped, which gives a latency of K in that case.
- R4: With `use_ext_sof` = 1, a frame is a boundary exactly when `ext_sof` is high in that frame.
- R5: With `use_ext_sof` = 0, a local counter is 0 in the first frame after reset and advances by one per frame, wrapping after K−1. A frame is a boundary when the count is 0. If `mf_frames` is 0 or 1, every frame is a boundary.
- R6: A capture writes exactly N frames (N = `capture_len`, a value of 0 treated as 1). `wr_en` is high in N consecutive frames with `wr_addr` = 0, 1, …, N−1.
- R7: `done` rises in the frame after the last write and stays high until a clear.
- R8: Trigger edges that arrive while the block is capturing or done have no effect: no write occurs, and `done` and `latency` do not change.
- R9: When `sw_clear` is high in a frame, the next frame shows `done`, `wr_en`, `wr_addr` and `latency` all zero, and the block is ready for a new trigger edge. Clear takes priority over every other event.
- R10: From the first write until the next clear, `latency` holds the number of frames from trigger detection to the first write (first-write frame index minus detection frame index).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock, one frame per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_async | input | 1 | External trigger, asynchronous to clk |
| use_ext_sof | input | 1 | 1: boundary from ext_sof; 0: from the local counter |
| ext_sof | input | 1 | External start-of-multiframe marker |
| mf_frames | input | KW | Frames per multiframe (K) |
| capture_len | input | AW | Frames to store per capture (N) |
| sw_clear | input | 1 | Synchronous re-arm and clear |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | AW | Buffer write address |
| done | output | 1 | Capture complete |
| latency | output | KW | Frames from trigger detection to capture start |

## Verification
The following are checked every cycle:
- A write burst can begin only on a boundary frame.
- Addresses advance by one across consecutive writes.
- `done` never coincides with a write, rises right after a write, and holds until clear.
- Trigger edges during capture or done leave `latency` unchanged.
- The local multiframe count only steps by one or returns to zero.

Some behaviour can only be shown by the directed scenarios:
- The exact frame of the first write relative to the trigger, including the skipped boundary in the detection frame.
- The latency value that results.
- The burst length N.
- That a held trigger level does not re-arm after a clear.

// File: rtl/mfcap_pkg.sv
package mfcap_pkg;

  // Capture sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // armed, waiting for trigger edge
    ST_WAIT = 2'd1,  // trigger seen, waiting for multiframe boundary
    ST_CAPT = 2'd2,  // writing frames
    ST_DONE = 2'd3   // capture finished, triggers ignored
  } cap_state_t;

endpackage

// File: rtl/mfcap_trig_sync.sv
module mfcap_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic trig_rise
);

  localparam int W = STAGES + 1;

  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[W-2:0], trig_async};
  end

  assign trig_rise = sh[STAGES-1] & ~sh[STAGES];

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise);

endmodule

// File: rtl/mfcap_mf_track.sv
module mfcap_mf_track #(
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_ext_sof,
  input  logic          ext_sof,
  input  logic [KW-1:0] k,
  output logic          mf_start
);

  logic [KW-1:0] cnt;

  function automatic logic [KW-1:0] next_count(input logic [KW-1:0] c,
                                               input logic [KW-1:0] kk);
    if (kk <= KW'(1) || c >= kk - KW'(1)) return '0;
    return c + KW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, k);
  end

  assign mf_start = use_ext_sof ? ext_sof : (cnt == '0);

  // R5
  mf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt == $past(cnt) + KW'(1)));

endmodule

// File: rtl/mfcap_seq.sv
module mfcap_seq
  import mfcap_pkg::*;
#(
  parameter int KW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_rise,
  input  logic          mf_start,
  input  logic          sw_clear,
  input  logic [AW-1:0] n,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          done,
  output logic [KW-1:0] latency
);

  cap_state_t    st;
  logic [AW-1:0] addr_q;
  logic [KW-1:0] lat_q;
  logic          start_now;

  function automatic logic [KW-1:0] sat_inc(input logic [KW-1:0] v);
    return (v == '1) ? v : v + KW'(1);
  endfunction

  function automatic logic is_last(input logic [AW-1:0] a,
                                   input logic [AW-1:0] len);
    return (len <= AW'(1)) || (a >= len - AW'(1));
  endfunction

  assign start_now = (st == ST_WAIT) && mf_start;
  assign wr_en     = start_now || (st == ST_CAPT);
  assign wr_addr   = addr_q;
  assign done      = (st == ST_DONE);
  assign latency   = lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      lat_q  <= '0;
    end else if (sw_clear) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      lat_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (trig_rise) begin
          st    <= ST_WAIT;
          lat_q <= KW'(1);
        end
        ST_WAIT: if (mf_start) begin
          if (is_last(AW'(0), n)) st <= ST_DONE;
          else begin
            st     <= ST_CAPT;
            addr_q <= AW'(1);
          end
        end else begin
          lat_q <= sat_inc(lat_q);
        end
        ST_CAPT: if (is_last(addr_q, n)) st <= ST_DONE;
                 else addr_q <= addr_q + AW'(1);
        ST_DONE: st <= ST_DONE;
      endcase
    end
  end

  // R3
  start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> mf_start);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1)));

  // R7
  done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sw_clear) |=> done);

  // R8
  ignore_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_CAPT || done) && trig_rise && !sw_clear) |=> (latency == $past(latency)));

  // R10
  latency_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_now |-> (latency != '0));

endmodule

// File: rtl/mfcap_ctrl.sv
module mfcap_ctrl #(
  parameter int KW          = 8,
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_async,
  input  logic          use_ext_sof,
  input  logic          ext_sof,
  input  logic [KW-1:0] mf_frames,
  input  logic [AW-1:0] capture_len,
  input  logic          sw_clear,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          done,
  output logic [KW-1:0] latency
);

  logic trig_rise;
  logic mf_start;

  mfcap_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_async (trig_async),
    .trig_rise  (trig_rise)
  );

  mfcap_mf_track #(.KW(KW)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_ext_sof (use_ext_sof),
    .ext_sof     (ext_sof),
    .k           (mf_frames),
    .mf_start    (mf_start)
  );

  mfcap_seq #(.KW(KW), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_rise (trig_rise),
    .mf_start  (mf_start),
    .sw_clear  (sw_clear),
    .n         (capture_len),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .done      (done),
    .latency   (latency)
  );

endmodule

// File: tb/sim_mfcap_ctrl.sv
module sim_mfcap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_async = 1'b0;
  logic          use_ext_sof = 1'b0;
  logic          ext_sof = 1'b0;
  logic          sw_clear = 1'b0;
  logic [KW-1:0] mf_frames = KW'(4);
  logic [AW-1:0] capture_len = AW'(1);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          done;
  logic [KW-1:0] latency;

  int slot = 0;
  int kval = 4;
  int bphase = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  mfcap_ctrl #(.KW(KW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_async(trig_async),
    .use_ext_sof(use_ext_sof), .ext_sof(ext_sof), .mf_frames(mf_frames),
    .capture_len(capture_len), .sw_clear(sw_clear), .wr_en(wr_en),
    .wr_addr(wr_addr), .done(done), .latency(latency)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Boundary frames per R4 (external marker phase) and R5 (local count 0)
  function automatic bit is_bound(int c);
    if (kval <= 1) return 1'b1;
    if (use_ext_sof) return (c % kval) == bphase;
    return (c % kval) == 0;
  endfunction

  function automatic int bound_phase();
    return use_ext_sof ? bphase : 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs sampled 1 time unit later
  task automatic advance();
    @(negedge clk);
    slot++;
    ext_sof = use_ext_sof && is_bound(slot);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig_async = 1'b0; sw_clear = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(wr_en == 1'b0 && done == 1'b0, "R1 reset wr_en/done", int'(wr_en) + int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    slot = 0;
    ext_sof = use_ext_sof && is_bound(0);
    #1;
    check(wr_en == 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(wr_addr == '0, "R1 wr_addr after reset", int'(wr_addr), 0);
    check(latency == '0, "R1 latency after reset", int'(latency), 0);
  endtask

  // R9: one-frame clear pulse, then everything reads zero
  task automatic do_clear();
    advance(); sw_clear = 1'b1; #1;
    advance(); sw_clear = 1'b0; #1;
    check(done == 1'b0, "R9 done after clear", int'(done), 0);
    check(wr_en == 1'b0, "R9 wr_en after clear", int'(wr_en), 0);
    check(wr_addr == '0, "R9 wr_addr after clear", int'(wr_addr), 0);
    check(latency == '0, "R9 latency after clear", int'(latency), 0);
  endtask

  // Pulse trigger, predict detection frame d = a+2 (R2), start s (R3)
  task automatic do_capture(int n, bit coincide, string tag);
    int a, d, s, last;
    capture_len = AW'(n);
    if (coincide)
      while (((slot + 3) % kval) != bound_phase()) advance();
    advance();
    trig_async = 1'b1;
    a = slot; d = a + 2; s = d + 1;
    while (!is_bound(s)) s++;
    last = s + n + 1;
    for (int c = a; c <= last; c++) begin
      bit exp_we, exp_done;
      if (c != a) begin
        advance();
        if (slot == a + 3) trig_async = 1'b0;
      end
      #1;
      exp_we   = (slot >= s) && (slot < s + n);
      exp_done = (slot >= s + n);
      check(wr_en == exp_we, {tag, " R3/R6 wr_en"}, int'(wr_en), int'(exp_we));
      if (exp_we)
        check(int'(wr_addr) == slot - s, {tag, " R6 wr_addr"}, int'(wr_addr), slot - s);
      check(done == exp_done, {tag, " R7 done"}, int'(done), int'(exp_done));
    end
    check(int'(latency) == s - d, {tag, " R10 latency"}, int'(latency), s - d);
    if (coincide)
      check(s - d == kval, {tag, " R3 skipped boundary"}, s - d, kval);
  endtask

  task automatic t_ext_basic();
    use_ext_sof = 1'b1; kval = 4; bphase = 1; mf_frames = KW'(4);
    do_reset();
    do_capture(5, 1'b0, "R4 ext");
    do_clear();
    repeat (2) advance();
    do_capture(3, 1'b0, "R4 ext second");
    do_clear();
  endtask

  task automatic t_coincide();
    do_capture(3, 1'b1, "R3 coincide ext");
    do_clear();
  endtask

  task automatic t_ignore();
    int held;
    do_capture(2, 1'b0, "R8 setup");
    held = int'(latency);
    advance(); trig_async = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (i == 0) #1; else begin advance(); if (i == 3) trig_async = 1'b0; #1; end
      check(wr_en == 1'b0, "R8 wr_en while done", int'(wr_en), 0);
      check(done == 1'b1, "R8 done held", int'(done), 1);
      check(int'(latency) == held, "R8 latency held", int'(latency), held);
    end
    do_clear();
  endtask

  task automatic t_level_held();
    capture_len = AW'(2);
    advance(); trig_async = 1'b1;
    repeat (14) advance();
    #1;
    check(done == 1'b1, "R2 capture from held level", int'(done), 1);
    do_clear();
    for (int i = 0; i < 16; i++) begin
      advance(); #1;
      check(wr_en == 1'b0, "R2 held level no rearm", int'(wr_en), 0);
      check(done == 1'b0, "R2 held level no done", int'(done), 0);
    end
    advance(); trig_async = 1'b0;
    repeat (3) advance();
    do_capture(2, 1'b0, "R2 fresh edge");
    do_clear();
  endtask

  task automatic t_local();
    use_ext_sof = 1'b0; kval = 5; mf_frames = KW'(5);
    do_reset();
    repeat (2) advance();
    do_capture(3, 1'b0, "R5 local");
    do_clear();
    do_capture(4, 1'b1, "R5 local coincide");
    do_clear();
  endtask

  task automatic t_k1();
    use_ext_sof = 1'b0; kval = 1; mf_frames = KW'(1);
    do_reset();
    do_capture(1, 1'b0, "R5 K=1 R6 N=1");
    check(latency == KW'(1), "R5 K=1 latency", int'(latency), 1);
    do_clear();
  endtask

  task automatic t_long();
    use_ext_sof = 1'b1; kval = 8; bphase = 3; mf_frames = KW'(8);
    do_reset();
    repeat (5) advance();
    do_capture(20, 1'b0, "R6 long ext");
    do_clear();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", slot, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_ext_basic();
    t_coincide();
    t_ignore();
    t_level_held();
    t_local();
    t_k1();
    t_long();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule